// File: doc/BRIEF.md
# Rotate-Immediate-and-Mask Execution Unit

This unit executes the 64-bit rotate-by-immediate-then-mask operation family and the arithmetic right shift by an immediate amount. Each cycle with `in_valid` high it takes one 32-bit instruction word, the source operand, the present destination value (needed by the insert variant) and the current summary-overflow bit. One cycle later it presents the 64-bit result and three write strobes: one for the destination, one for the 4-bit condition field and one for the carry bit. It decodes the instruction itself. That includes reassembling the 6-bit shift amount and the 6-bit mask bound, which are both split across the instruction word.

Every variant uses one shared left rotator and one mask generator. The mask covers a range in MSB-0 numbering, where data bit 0 is the most significant bit. When the start of the range lies past its end, the range wraps around. The arithmetic shift is built as a rotation by `64 - n` with the mask running from n to 63, and the sign bit fills the bits outside the mask.

Top module: `rim_exec_unit`

## Requirements
- R1: With primary opcode 0b011110 (instr[31:26]) and sub-code 000 (instr[4:2]), the result is the source rotated left by the shift amount n, ANDed with a mask that is ones from position mb through 63 (MSB-0 numbering), and `wr_en` is 1.
- R2: With sub-code 001, the mask is ones from position 0 through the mask bound me.
- R3: With sub-code 010, the mask runs from mb through the bitwise complement of n, which is 63 - n.
- R4: With sub-code 011 (insert), the mask is formed as in R3. The result takes the rotated source where the mask is 1 and `dst_val` where the mask is 0.
- R5: The shift amount is {instr[1], instr[15:11]}, which is instruction bit 30 in MSB-0 numbering followed by bits 16..20. The mask bound is {instr[5], instr[10:6]}, which is the last bit of the field followed by its first five bits.
- R6: When the mask start is greater than the mask end, the mask is ones at the start position through 63 and at 0 through the end position, and zeros in between.
- R7: With opcode 0b011111 and extended code instr[10:2] = 0b110011101, the result is the source shifted right arithmetically by n.
- R8: For the arithmetic shift, `ca_we` is 1 and `ca` is 1 exactly when the source is negative, n is nonzero and at least one 1 bit was shifted out. For every other operation, `ca_we` and `ca` are 0.
- R9: When the record bit instr[0] is 1 on a legal operation, `cond_we` is 1 and `cond` = {negative, positive, zero, so_in}, with negative in cond[3]. Otherwise `cond_we` and `cond` are 0.
- R10: Any other encoding, including sub-codes 100 to 111, drives `illegal` to 1 and `wr_en`, `cond_we` and `ca_we` to 0.
- R11: Outputs appear one clock after the accepted input, and `out_valid` follows `in_valid` with that same delay. In a cycle without `out_valid`, every strobe is 0 and `result` holds its last value.
- R12: After reset, `out_valid`, `result` and every strobe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands present |
| instr | input | 32 | Instruction word |
| src_val | input | 64 | Source operand |
| dst_val | input | 64 | Current destination value, used by insert |
| so_in | input | 1 | Summary-overflow bit |
| out_valid | output | 1 | Registered result present |
| result | output | 64 | Operation result |
| wr_en | output | 1 | Destination write strobe |
| illegal | output | 1 | Encoding not recognised |
| cond_we | output | 1 | Condition field write strobe |
| cond | output | 4 | {negative, positive, zero, summary overflow} |
| ca_we | output | 1 | Carry write strobe |
| ca | output | 1 | Carry value |

## Verification
The condition update and the carry update can both happen in one cycle. This occurs when an arithmetic shift carries the record bit. The bench provokes it with a negative source whose shifted-out bits contain ones, and then with n = 0. In both cases the flags, the carry and the result must each match a reference computed independently from the requirements, all in the same output cycle.

// File: rtl/rim_pkg.sv
package rim_pkg;
    localparam int XLEN = 64;
    localparam int SHW  = $clog2(XLEN);

    typedef enum logic [2:0] {
        MODE_HEAD  = 3'd0,
        MODE_TAIL  = 3'd1,
        MODE_SPAN  = 3'd2,
        MODE_MERGE = 3'd3,
        MODE_ARITH = 3'd4,
        MODE_BAD   = 3'd7
    } rim_mode_e;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] result;
        logic            wr_en;
        logic            illegal;
        logic            cond_we;
        logic [3:0]      cond;
        logic            ca_we;
        logic            ca;
    } rim_out_t;
endpackage

// File: rtl/rim_decode.sv
module rim_decode
    import rim_pkg::*;
(
    input  logic [31:0]    instr,
    output rim_mode_e      mode,
    output logic [SHW-1:0] shamt,
    output logic [SHW-1:0] bound,
    output logic           rec
);
    localparam logic [5:0] PRI_ROT = 6'b011110;
    localparam logic [5:0] PRI_ALU = 6'b011111;
    localparam logic [8:0] XO_SRA  = 9'b110011101;

    logic unused_regs;
    assign unused_regs = ^instr[25:16];

    always_comb begin
        mode = MODE_BAD;
        if (instr[31:26] == PRI_ROT) begin
            case (instr[4:2])
                3'b000:  mode = MODE_HEAD;
                3'b001:  mode = MODE_TAIL;
                3'b010:  mode = MODE_SPAN;
                3'b011:  mode = MODE_MERGE;
                default: mode = MODE_BAD;
            endcase
        end else if (instr[31:26] == PRI_ALU && instr[10:2] == XO_SRA) begin
            mode = MODE_ARITH;
        end
    end

    assign shamt = {instr[1], instr[15:11]};
    assign bound = {instr[5], instr[10:6]};
    assign rec   = instr[0];
endmodule

// File: rtl/rim_rotator.sv
module rim_rotator #(
    parameter int W = 64
) (
    input  logic [W-1:0]         din,
    input  logic [$clog2(W)-1:0] amt,
    output logic [W-1:0]         dout
);
    localparam int STAGES = $clog2(W);

    logic [W-1:0] stage [0:STAGES];

    assign stage[0] = din;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amt[k] ? {stage[k][W-1-STEP:0], stage[k][W-1:W-STEP]}
                                   : stage[k];
    end

    assign dout = stage[STAGES];
endmodule

// File: rtl/rim_mask_gen.sv
module rim_mask_gen #(
    parameter int W = 64
) (
    input  logic [$clog2(W)-1:0] first,
    input  logic [$clog2(W)-1:0] last,
    output logic [W-1:0]         mask
);
    logic [W-1:0] all_ones;
    logic [W-1:0] from_first;
    logic [W-1:0] upto_last;

    always_comb begin
        all_ones   = '1;
        from_first = all_ones >> first;
        upto_last  = ~((all_ones >> last) >> 1);
        if (first <= last) mask = from_first & upto_last;
        else               mask = from_first | upto_last;
    end
endmodule

// File: rtl/rim_exec_unit.sv
module rim_exec_unit
    import rim_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] src_val,
    input  logic [XLEN-1:0] dst_val,
    input  logic            so_in,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic            wr_en,
    output logic            illegal,
    output logic            cond_we,
    output logic [3:0]      cond,
    output logic            ca_we,
    output logic            ca
);
    localparam logic [SHW-1:0] TOP_POS = SHW'(XLEN - 1);

    rim_mode_e      mode;
    logic [SHW-1:0] shamt;
    logic [SHW-1:0] bound;
    logic           rec;
    logic [SHW-1:0] rot_amt;
    logic [SHW-1:0] m_first;
    logic [SHW-1:0] m_last;
    logic [XLEN-1:0] rotated;
    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] res;
    logic           legal;
    logic           sign;
    logic           carry;
    logic [3:0]     flags;
    rim_out_t       out_d, out_q;

    rim_decode u_dec (
        .instr (instr),
        .mode  (mode),
        .shamt (shamt),
        .bound (bound),
        .rec   (rec)
    );

    rim_rotator #(.W(XLEN)) u_rot (
        .din  (src_val),
        .amt  (rot_amt),
        .dout (rotated)
    );

    rim_mask_gen #(.W(XLEN)) u_mask (
        .first (m_first),
        .last  (m_last),
        .mask  (mask)
    );

    // Operand routing for the shared rotator and mask generator
    always_comb begin
        rot_amt = (mode == MODE_ARITH) ? (SHW'(0) - shamt) : shamt;
        m_first = '0;
        m_last  = TOP_POS;
        case (mode)
            MODE_HEAD:  begin m_first = bound; m_last = TOP_POS; end
            MODE_TAIL:  begin m_first = '0;    m_last = bound;   end
            MODE_SPAN,
            MODE_MERGE: begin m_first = bound; m_last = ~shamt;  end
            MODE_ARITH: begin m_first = shamt; m_last = TOP_POS; end
            default:    begin m_first = '0;    m_last = TOP_POS; end
        endcase
    end

    // Result, flags and next register state
    always_comb begin
        sign  = src_val[XLEN-1];
        legal = (mode != MODE_BAD);
        case (mode)
            MODE_HEAD,
            MODE_TAIL,
            MODE_SPAN:  res = rotated & mask;
            MODE_MERGE: res = (rotated & mask) | (dst_val & ~mask);
            MODE_ARITH: res = (rotated & mask) | ({XLEN{sign}} & ~mask);
            default:    res = '0;
        endcase
        carry = (mode == MODE_ARITH) && (shamt != '0) && sign && (|(rotated & ~mask));
        flags = {res[XLEN-1], ~res[XLEN-1] & (|res), ~(|res), so_in};

        out_d         = out_q;
        out_d.valid   = in_valid;
        out_d.wr_en   = 1'b0;
        out_d.illegal = 1'b0;
        out_d.cond_we = 1'b0;
        out_d.cond    = '0;
        out_d.ca_we   = 1'b0;
        out_d.ca      = 1'b0;
        if (in_valid) begin
            out_d.result  = res;
            out_d.wr_en   = legal;
            out_d.illegal = ~legal;
            out_d.cond_we = legal & rec;
            out_d.cond    = (legal & rec) ? flags : 4'b0000;
            out_d.ca_we   = (mode == MODE_ARITH);
            out_d.ca      = carry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid = out_q.valid;
    assign result    = out_q.result;
    assign wr_en     = out_q.wr_en;
    assign illegal   = out_q.illegal;
    assign cond_we   = out_q.cond_we;
    assign cond      = out_q.cond;
    assign ca_we     = out_q.ca_we;
    assign ca        = out_q.ca;
endmodule

// File: rtl/rim_exec_unit_chk.sv
module rim_exec_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        so_in,
    input logic        out_valid,
    input logic [63:0] result,
    input logic        wr_en,
    input logic        illegal,
    input logic        cond_we,
    input logic [3:0]  cond,
    input logic        ca_we,
    input logic        ca
);
    // R11: output valid tracks input valid one cycle later
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r11_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r11_strobes_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || illegal || cond_we || ca_we) |-> out_valid);
    a_r11_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !in_valid) |=> $stable(result));
    // R10: an illegal encoding writes nothing
    a_r10_illegal_excl: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wr_en && !cond_we && !ca_we));
    // R9: exactly one of negative/positive/zero is reported
    a_r9_cond_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        cond_we |-> ($countones(cond[3:1]) == 1));
    a_r9_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_we && cond[1]) |-> (result == 64'd0));
    a_r9_so_copy: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!cond_we || (cond[0] == $past(so_in))));
    // R8: carry only raised with its own write strobe
    a_r8_carry_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ca |-> ca_we);
endmodule

bind rim_exec_unit rim_exec_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .so_in     (so_in),
    .out_valid (out_valid),
    .result    (result),
    .wr_en     (wr_en),
    .illegal   (illegal),
    .cond_we   (cond_we),
    .cond      (cond),
    .ca_we     (ca_we),
    .ca        (ca)
);

// File: tb/rim_exec_unit_tb.sv
`timescale 1ns/1ps
module rim_exec_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] src_val = '0;
    logic [63:0] dst_val = '0;
    logic        so_in = 1'b0;
    logic        out_valid, wr_en, illegal, cond_we, ca_we, ca;
    logic [63:0] result;
    logic [3:0]  cond;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    rim_exec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src_val(src_val), .dst_val(dst_val), .so_in(so_in),
        .out_valid(out_valid), .result(result), .wr_en(wr_en),
        .illegal(illegal), .cond_we(cond_we), .cond(cond),
        .ca_we(ca_we), .ca(ca)
    );

    // ---------------- reference model ----------------
    function automatic logic [63:0] ref_mask(int b, int e);
        logic [63:0] m = '0;
        for (int p = 0; p < 64; p++) begin
            bit on = (b <= e) ? (p >= b && p <= e) : (p >= b || p <= e);
            if (on) m[63-p] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [63:0] ref_rotl(logic [63:0] x, int n);
        logic [63:0] r = '0;
        for (int i = 0; i < 64; i++) r[(i + n) % 64] = x[i];
        return r;
    endfunction

    function automatic logic [63:0] ref_rot(int sub, int n, int mb, logic [63:0] s, logic [63:0] d);
        logic [63:0] r = ref_rotl(s, n);
        logic [63:0] m;
        case (sub)
            0:       m = ref_mask(mb, 63);
            1:       m = ref_mask(0, mb);
            default: m = ref_mask(mb, 63 - n);
        endcase
        if (sub == 3) return (r & m) | (d & ~m);
        return r & m;
    endfunction

    function automatic logic [3:0] ref_cond(logic [63:0] r, logic so);
        logic neg = r[63];
        logic zer = (r == 64'd0);
        return {neg, !neg && !zer, zer, so};
    endfunction

    function automatic logic [31:0] enc_rot(int sub, int n, int mb, bit rc);
        logic [5:0] s6 = 6'(n);
        logic [5:0] m6 = 6'(mb);
        return {6'b011110, 10'd0, s6[4:0], m6[4:0], m6[5], 3'(sub), s6[5], rc};
    endfunction

    function automatic logic [31:0] enc_sra(int n, bit rc);
        logic [5:0] s6 = 6'(n);
        return {6'b011111, 10'd0, s6[4:0], 9'b110011101, s6[5], rc};
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_out(string tag, logic [63:0] r, bit we, bit cwe,
                              logic [3:0] c, bit cawe, bit cav, bit ill);
        chk({tag, " out_valid"}, 64'(out_valid), 64'd1);
        chk({tag, " result"},    result, r);
        chk({tag, " wr_en"},     64'(wr_en), 64'(we));
        chk({tag, " cond_we"},   64'(cond_we), 64'(cwe));
        chk({tag, " cond"},      64'(cond), 64'(c));
        chk({tag, " ca_we"},     64'(ca_we), 64'(cawe));
        chk({tag, " ca"},        64'(ca), 64'(cav));
        chk({tag, " illegal"},   64'(illegal), 64'(ill));
    endtask

    task automatic issue(logic [31:0] i, logic [63:0] s, logic [63:0] d, logic so);
        @(negedge clk);
        instr = i; src_val = s; dst_val = d; so_in = so; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_rot(string tag, int sub, int n, int mb, logic [63:0] s, logic [63:0] d);
        logic [63:0] e = ref_rot(sub, n, mb, s, d);
        issue(enc_rot(sub, n, mb, 1'b0), s, d, 1'b0);
        expect_out(tag, e, 1'b1, 1'b0, 4'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic run_sra(string tag, int n, logic [63:0] s, bit rc, logic so);
        logic [63:0] e = 64'($signed(s) >>> n);
        logic [63:0] lowm = (n == 0) ? 64'd0 : ((64'd1 << n) - 64'd1);
        bit c = (n != 0) && s[63] && ((s & lowm) != 64'd0);
        issue(enc_sra(n, rc), s, 64'd0, so);
        expect_out(tag, e, 1'b1, rc, rc ? ref_cond(e, so) : 4'b0, 1'b1, c, 1'b0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R12 reset out_valid", 64'(out_valid), 64'd0);
        chk("R12 reset result", result, 64'd0);
        chk("R12 reset strobes", 64'({wr_en, illegal, cond_we, ca_we, ca}), 64'd0);
        chk("R12 reset cond", 64'(cond), 64'd0);
    endtask

    task automatic t_head();
        run_rot("R1 head clear n=12 mb=20", 0, 12, 20, 64'h8123_4567_89AB_CDEF, 64'd0);
        run_rot("R1 head clear n=0 mb=0", 0, 0, 0, 64'hDEAD_BEEF_0123_4567, 64'd0);
    endtask

    task automatic t_tail();
        run_rot("R2 tail clear n=7 me=40", 1, 7, 40, 64'hF0F0_1234_5678_9ABC, 64'd0);
        run_rot("R2 tail clear n=63 me=63", 1, 63, 63, 64'h0000_0000_0000_0003, 64'd0);
    endtask

    task automatic t_span();
        run_rot("R3 span n=16 mb=8", 2, 16, 8, 64'h0123_4567_89AB_CDEF, 64'd0);
    endtask

    task automatic t_merge();
        run_rot("R4 insert n=20 mb=10", 3, 20, 10, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0);
        run_rot("R4 insert n=0 mb=32", 3, 0, 32, 64'hAAAA_AAAA_5555_5555, 64'h0F0F_0F0F_0F0F_0F0F);
    endtask

    task automatic t_fields();
        // high halves of both split fields set
        run_rot("R5 split fields n=45 mb=37", 0, 45, 37, 64'h1122_3344_5566_7788, 64'd0);
        run_rot("R5 split fields n=33 me=48", 1, 33, 48, 64'h8000_0000_0000_0001, 64'd0);
    endtask

    task automatic t_wrap();
        run_rot("R6 wrap span n=8 mb=60", 2, 8, 60, 64'hFEDC_BA98_7654_3210, 64'd0);
        run_rot("R6 wrap insert n=40 mb=50", 3, 40, 50, 64'hFFFF_0000_FFFF_0000, 64'h5A5A_5A5A_5A5A_5A5A);
    endtask

    task automatic t_sra();
        run_sra("R7 sra positive n=5", 5, 64'h7FF0_0000_0000_001F, 1'b0, 1'b0);
        run_sra("R8 sra negative ones out n=36", 36, 64'hF000_0000_0000_0010, 1'b0, 1'b0);
        run_sra("R8 sra negative zeros out n=4", 4, 64'h8000_0000_0000_0000, 1'b0, 1'b0);
        run_sra("R8 sra n=0 no carry", 0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
    endtask

    task automatic t_record();
        logic [63:0] e;
        issue(enc_rot(0, 0, 0, 1'b1), 64'd0, 64'd0, 1'b1);
        expect_out("R9 record zero so=1", 64'd0, 1'b1, 1'b1, 4'b0011, 1'b0, 1'b0, 1'b0);
        e = ref_rot(1, 4, 63, 64'h0800_0000_0000_0000, 64'd0);
        issue(enc_rot(1, 4, 63, 1'b1), 64'h0800_0000_0000_0000, 64'd0, 1'b0);
        expect_out("R9 record negative", e, 1'b1, 1'b1, 4'b1000, 1'b0, 1'b0, 1'b0);
        // condition and carry in the same cycle
        run_sra("R9 R8 sra record carry", 3, 64'h8000_0000_0000_0007, 1'b1, 1'b1);
        run_sra("R9 R8 sra record n=0", 0, 64'h0000_0000_0000_0042, 1'b1, 1'b0);
    endtask

    task automatic t_illegal();
        issue(enc_rot(1, 3, 3, 1'b0), 64'h1, 64'h2, 1'b0);
        chk("R10 legal before illegal", 64'(wr_en), 64'd1);
        issue({6'b011110, 10'd0, 5'd1, 6'd0, 3'b100, 1'b0, 1'b1}, 64'hFFFF, 64'd0, 1'b1);
        expect_out("R10 sub-code 100", 64'd0, 1'b0, 1'b0, 4'b0, 1'b0, 1'b0, 1'b1);
        issue({6'b011111, 10'd0, 5'd1, 9'b110011100, 1'b0, 1'b0}, 64'h8000_0000_0000_0001, 64'd0, 1'b0);
        expect_out("R10 wrong extended code", 64'd0, 1'b0, 1'b0, 4'b0, 1'b0, 1'b0, 1'b1);
        issue({6'b000111, 26'h3FF_FFFF}, 64'h1, 64'd0, 1'b0);
        expect_out("R10 other opcode", 64'd0, 1'b0, 1'b0, 4'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_latency();
        logic [63:0] ea = ref_rot(0, 4, 0, 64'h0000_0000_0000_00FF, 64'd0);
        logic [63:0] eb = ref_rot(1, 60, 31, 64'h1234_0000_0000_0000, 64'd0);
        @(negedge clk);
        instr = enc_rot(0, 4, 0, 1'b0); src_val = 64'h0000_0000_0000_00FF; in_valid = 1'b1;
        @(negedge clk);
        chk("R11 first result after one clock", result, ea);
        chk("R11 first valid", 64'(out_valid), 64'd1);
        instr = enc_rot(1, 60, 31, 1'b0); src_val = 64'h1234_0000_0000_0000;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R11 back-to-back second result", result, eb);
        @(negedge clk);
        chk("R11 idle out_valid", 64'(out_valid), 64'd0);
        chk("R11 idle strobes", 64'({wr_en, illegal, cond_we, ca_we}), 64'd0);
        chk("R11 idle result held", result, eb);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL R11 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_head();
        t_tail();
        t_span();
        t_merge();
        t_fields();
        t_wrap();
        t_sra();
        t_record();
        t_illegal();
        t_latency();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule